// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the branch's own recent outcomes rather than global path history. Low bits of the branch address select one of a small set of per-branch shift registers. Each register records the last few outcomes of the branches that map to it. That recorded pattern then picks one 2-bit saturating counter from a second table. The counter's upper bit is the prediction. Because the second level is keyed by this branch's own past, periodic behaviour such as strict taken/not-taken alternation can be learned, which a plain per-address counter cannot do.

A fetch stage presents a lookup address each cycle and reads the prediction in the same cycle, with no register in that path. When a branch resolves later in the pipeline, its address and real outcome arrive on the resolve port. On that clock edge the counter picked by the branch's current history is trained, and the outcome is shifted into its history register. Targets, tags and speculative history update are handled elsewhere.

Top module: `lhp_top`

## Requirements
- R1: The history register for an address is chosen by address bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS], with IDX_W = log2(HIST_ENTRIES) (defaults: 16 entries, bits [5:2]). There are no tags, so two addresses that differ only outside those bits share one history register and get the same prediction.
- R2: After reset every history register is zero and every counter is 01 (weakly not-taken). Every lookup then predicts not-taken.
- R3: `predTaken` is bit 1 of the counter indexed by the history register selected by `lookupPc`. It is produced combinationally in the same cycle.
- R4: On a clock edge with `resolveValid` high, the counter indexed by the resolving branch's current history goes up by one if `resolveTaken` is 1 and down by one if it is 0. It saturates at 11 and 00.
- R5: On the same edge, the resolving branch's history register becomes {old history without its oldest bit, resolveTaken}. The newest outcome is in bit 0.
- R6: A cycle with `resolveValid` low changes no history register and no counter.
- R7: When a lookup and a resolve hit the same entry in the same cycle, the lookup returns the prediction from the state before that update.
- R8: A branch that strictly alternates taken and not-taken, resolved once per lookup, is predicted correctly on every instance after a warm-up of at most 12 instances, given HIST_W of at least 2.
- R9: A counter driven to 11 still predicts taken after one not-taken outcome trained against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset; clears all histories and sets all counters to weakly not-taken |
| lookupPc | input | PC_W | Address of the branch being fetched |
| predTaken | output | 1 | Predicted direction for `lookupPc` (1 = taken) |
| resolveValid | input | 1 | A branch outcome is presented this cycle |
| resolvePc | input | PC_W | Address of the resolving branch |
| resolveTaken | input | 1 | Actual outcome of the resolving branch |

## Verification
On every cycle the assertions check the following. The counters never step past 00 or 11 and move by exactly one when trained. The newest history bit equals the resolved outcome. Nothing in either table moves on an idle cycle. Prediction is not-taken right after reset. Only the bench scenarios can show the end-to-end learning behaviour: the alternating pattern converging, hysteresis surviving a single opposite outcome, untagged aliasing between addresses, and the pre-update value on a same-cycle collision. A reference model in the bench checks each prediction under random mixes of branches.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  // Strobes from the control to the datapath for one resolve event.
  typedef struct packed {
    logic histWe;   // shift the outcome into the selected history register
    logic cntInc;   // step the selected counter toward taken
    logic cntDec;   // step the selected counter toward not-taken
  } lhpStrobe_t;

  localparam logic [1:0] CNT_RESET = 2'b01;
  localparam logic [1:0] CNT_MAX   = 2'b11;
  localparam logic [1:0] CNT_MIN   = 2'b00;

endpackage

// File: rtl/lhp_control.sv
module lhp_control
  import lhp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resolveValid,
  input  logic       resolveTaken,
  input  logic [1:0] resolveCnt,
  output lhpStrobe_t strobe
);

  logic atMax;
  logic atMin;

  always_comb begin
    atMax = (resolveCnt == CNT_MAX);
    atMin = (resolveCnt == CNT_MIN);
    strobe.histWe = resolveValid;
    strobe.cntInc = resolveValid && resolveTaken && !atMax;
    strobe.cntDec = resolveValid && !resolveTaken && !atMin;
  end

  // R4: the counter only moves one way per event
  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cntInc, strobe.cntDec}));

  // R4: no increment is requested on a counter that the datapath reports saturated high
  a_r4_no_wrap_high: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc |-> resolveCnt != CNT_MAX);

  // R4: no decrement is requested on a counter that the datapath reports saturated low
  a_r4_no_wrap_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |-> resolveCnt != CNT_MIN);

endmodule

// File: rtl/lhp_datapath.sv
module lhp_datapath
  import lhp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int HIST_ENTRIES = 16,
  parameter int HIST_W       = 4,
  parameter int ALIGN_BITS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  input  lhpStrobe_t      strobe,
  output logic            predTaken,
  output logic [1:0]      resolveCnt
);

  localparam int IDX_W = $clog2(HIST_ENTRIES);
  localparam int PHT_N = 1 << HIST_W;

  logic [HIST_ENTRIES-1:0][HIST_W-1:0] histTable;
  logic [PHT_N-1:0][1:0]               phtTable;

  logic [IDX_W-1:0]  lookupIdx;
  logic [IDX_W-1:0]  resolveIdx;
  logic [HIST_W-1:0] lookupHist;
  logic [HIST_W-1:0] resolveHist;
  logic [HIST_W-1:0] nextHist;
  logic [1:0]        cntUp;
  logic [1:0]        cntDown;

  // First level: address-selected local history
  always_comb begin
    lookupIdx   = lookupPc[ALIGN_BITS +: IDX_W];
    resolveIdx  = resolvePc[ALIGN_BITS +: IDX_W];
    lookupHist  = histTable[lookupIdx];
    resolveHist = histTable[resolveIdx];
  end

  // Second level: history-selected counter
  always_comb begin
    predTaken  = phtTable[lookupHist][1];
    resolveCnt = phtTable[resolveHist];
    cntUp      = resolveCnt + 2'd1;
    cntDown    = resolveCnt - 2'd1;
  end

  // Shift variant chosen by history width
  generate
    if (HIST_W > 1) begin : g_shift_wide
      assign nextHist = {resolveHist[HIST_W-2:0], resolveTaken};
    end else begin : g_shift_one
      assign nextHist = resolveTaken;
    end
  endgenerate

  // One register per history entry
  generate
    for (genvar h = 0; h < HIST_ENTRIES; h++) begin : g_hist
      logic entryWe;
      assign entryWe = strobe.histWe && (resolveIdx == IDX_W'(h));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          histTable[h] <= '0;
        end else if (entryWe) begin
          histTable[h] <= nextHist;
        end
      end
    end
  endgenerate

  // One saturating counter per history pattern
  generate
    for (genvar p = 0; p < PHT_N; p++) begin : g_pht
      logic hit;
      assign hit = (resolveHist == HIST_W'(p));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          phtTable[p] <= CNT_RESET;
        end else if (hit && strobe.cntInc) begin
          phtTable[p] <= cntUp;
        end else if (hit && strobe.cntDec) begin
          phtTable[p] <= cntDown;
        end
      end
    end
  endgenerate

  // R5: the newest history bit of the written entry is the resolved outcome
  a_r5_newest_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.histWe |=> histTable[$past(resolveIdx)][0] == $past(resolveTaken));

  // R6: histories hold when nothing resolves
  a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.histWe |=> $stable(histTable));

  // R6: counters hold when no step is requested
  a_r6_pht_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntInc || strobe.cntDec) |=> $stable(phtTable));

  // R4: a trained counter lands exactly one step up
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc |=> phtTable[$past(resolveHist)] == $past(resolveCnt) + 2'd1);

  // R4: a trained counter lands exactly one step down
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |=> phtTable[$past(resolveHist)] == $past(resolveCnt) - 2'd1);

endmodule

// File: rtl/lhp_top.sv
module lhp_top
  import lhp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int HIST_ENTRIES = 16,
  parameter int HIST_W       = 4,
  parameter int ALIGN_BITS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken
);

  lhpStrobe_t strobe;
  logic [1:0] resolveCnt;

  lhp_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .resolveValid(resolveValid),
    .resolveTaken(resolveTaken),
    .resolveCnt  (resolveCnt),
    .strobe      (strobe)
  );

  lhp_datapath #(
    .PC_W        (PC_W),
    .HIST_ENTRIES(HIST_ENTRIES),
    .HIST_W      (HIST_W),
    .ALIGN_BITS  (ALIGN_BITS)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .lookupPc    (lookupPc),
    .resolvePc   (resolvePc),
    .resolveTaken(resolveTaken),
    .strobe      (strobe),
    .predTaken   (predTaken),
    .resolveCnt  (resolveCnt)
  );

  // R2: first cycle out of reset predicts not-taken for any address
  a_r2_reset_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predTaken);

endmodule

// File: tb/tb_lhp_top.sv
module tb_lhp_top;

  localparam int PC_W    = 32;
  localparam int ENTRIES = 16;
  localparam int HW      = 4;
  localparam int ALIGN   = 2;
  localparam int IDX_W   = 4;
  localparam int PHT_N   = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic            predTaken;
  logic            resolveValid = 1'b0;
  logic [PC_W-1:0] resolvePc = '0;
  logic            resolveTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [HW-1:0] mHist [ENTRIES];
  logic [1:0]    mPht  [PHT_N];

  always #5 clk = ~clk;

  lhp_top #(.PC_W(PC_W), .HIST_ENTRIES(ENTRIES), .HIST_W(HW), .ALIGN_BITS(ALIGN)) dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .resolveValid(resolveValid), .resolvePc(resolvePc), .resolveTaken(resolveTaken)
  );

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[ALIGN +: IDX_W]);
  endfunction

  function automatic logic modelPred(input logic [PC_W-1:0] pc);
    return mPht[mHist[idxOf(pc)]][1];
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < ENTRIES; i++) mHist[i] = '0;
    for (int i = 0; i < PHT_N; i++) mPht[i] = 2'b01;
  endfunction

  function automatic void modelUpdate(input logic [PC_W-1:0] pc, input logic t);
    int e;
    logic [HW-1:0] h;
    e = idxOf(pc);
    h = mHist[e];
    if (t && mPht[h] != 2'b11) mPht[h] = mPht[h] + 2'd1;
    if (!t && mPht[h] != 2'b00) mPht[h] = mPht[h] - 2'd1;
    mHist[e] = {h[HW-2:0], t};
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: predTaken=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive one cycle; the prediction is checked before the edge (pre-update).
  task automatic step(input logic [PC_W-1:0] lpc, input logic v,
                      input logic [PC_W-1:0] rpc, input logic t, input string req);
    @(negedge clk);
    lookupPc = lpc; resolveValid = v; resolvePc = rpc; resolveTaken = t;
    #1;
    check(predTaken, modelPred(lpc), req);
    @(posedge clk);
    #1;
    if (v) modelUpdate(rpc, t);
  endtask

  task automatic idle();
    @(negedge clk);
    resolveValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pcAlt, pcHys, pcA, pcB, pcC;
    logic [PC_W-1:0] pool [8];
    int unused;
    unused = $urandom(32'h5eed_1234);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R2: every history entry predicts not-taken from reset
    for (int i = 0; i < ENTRIES; i++) begin
      @(negedge clk);
      lookupPc = PC_W'(i << ALIGN);
      #1;
      check(predTaken, 1'b0, "R2 reset predicts not-taken");
    end

    // R8: strictly alternating branch, lookup and resolve each instance
    pcAlt = 32'h0000_1008;
    for (int i = 0; i < 40; i++) begin
      logic outcome;
      outcome = (i % 2 == 0);
      @(negedge clk);
      lookupPc = pcAlt; resolveValid = 1'b1; resolvePc = pcAlt; resolveTaken = outcome;
      #1;
      check(predTaken, modelPred(pcAlt), "R3 alternating model");
      if (i >= 12) check(predTaken, outcome, "R8 alternating learned");
      @(posedge clk);
      #1;
      modelUpdate(pcAlt, outcome);
    end

    // R9: saturate the all-taken counter, one not-taken, then back to all-taken history
    pcHys = 32'h0000_2010;
    for (int i = 0; i < 10; i++) step(pcHys, 1'b1, pcHys, 1'b1, "R4 saturate up");
    step(pcHys, 1'b1, pcHys, 1'b0, "R4 single not-taken");
    for (int i = 0; i < 4; i++) step(pcHys, 1'b1, pcHys, 1'b1, "R5 refill history");
    idle();
    @(negedge clk);
    lookupPc = pcHys;
    #1;
    check(predTaken, 1'b1, "R9 hysteresis keeps taken");

    // R1: aliasing between addresses sharing index bits [5:2]
    pcA = 32'h0000_3004;
    pcB = pcA + 32'h40;
    pcC = pcA + 32'h4;
    for (int i = 0; i < 8; i++) step(pcA, 1'b1, pcA, 1'b1, "R4 train alias");
    @(negedge clk);
    resolveValid = 1'b0;
    lookupPc = pcB;
    #1;
    check(predTaken, 1'b1, "R1 aliased address shares history");
    lookupPc = pcC;
    #1;
    check(predTaken, modelPred(pcC), "R1 neighbour index separate");

    // R7: same-cycle lookup and resolve on one entry returns pre-update value
    for (int i = 0; i < 3; i++) step(pcA, 1'b1, pcA, 1'b0, "R7 collision pre-update");
    @(negedge clk);
    resolveValid = 1'b0; lookupPc = pcA;
    #1;
    check(predTaken, modelPred(pcA), "R7 post-update state");

    // R6: idle cycles leave all predictions untouched
    for (int i = 0; i < 5; i++) idle();
    for (int i = 0; i < ENTRIES; i++) begin
      @(negedge clk);
      lookupPc = PC_W'(i << ALIGN) + 32'h100;
      #1;
      check(predTaken, modelPred(lookupPc), "R6 idle holds state");
    end

    // Constrained random: small branch pool with aliasing and per-branch bias
    for (int i = 0; i < 8; i++) pool[i] = PC_W'(($urandom % 24) << ALIGN) + 32'h8000;
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] lp, rp;
      logic v, t;
      int sel;
      lp = pool[$urandom % 8];
      sel = $urandom % 8;
      rp = pool[sel];
      v = ($urandom % 10) < 7;
      if (sel < 3) t = (n % 2 == 0);
      else if (sel < 5) t = ($urandom % 10) < 9;
      else t = $urandom % 2;
      step(lp, v, rp, t, "R3 random prediction");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule